// File: doc/BRIEF.md
# ADC Regular Conversion Sequencer

This block walks an analog-to-digital converter through a programmed run of conversion slots. A start request takes a snapshot of the configuration: the continuous flag, the sequence-mode flag and a 4-bit length. The block then issues one start-conversion pulse per slot, always beginning at slot 0. Each conversion-done pulse from the converter timing logic moves it on to the next slot. When sequence mode is off, the run shrinks to slot 0 alone.

With continuous mode off, the block goes idle after the last slot converts. With continuous mode on, it wraps back to slot 0 and keeps converting until software raises a stop request. A stop request lets the conversion in flight finish and then halts the block.

A small table maps each slot to a channel number. The entry for the active slot is always presented at the output.

Top module: `conv_sequencer`

## Requirements
- R1: After reset: busy=0, soc=0, eos=0, slot_idx=0. Table entry i holds channel number i.
- R2: A start request while idle sets busy=1 one cycle later. In that same cycle soc pulses high for one cycle and slot_idx=0.
- R3: A length value N (cfg_len, 4 bits) gives N+1 conversions on slots 0,1,..,N in order. The slot advances once per accepted done, and each new slot is announced by a one-cycle soc pulse in the cycle slot_idx changes.
- R4: With cfg_seq_on=0, only slot 0 is converted, whatever cfg_len holds. This is the same as cfg_seq_on=1 with cfg_len=0.
- R5: In single mode (cfg_cont=0), the cycle after the done of the last slot shows busy=0 and soc=0, and no further soc follows. While idle, slot_idx reads 0.
- R6: eos is high for exactly one cycle, the cycle after the done of the last slot. It is never high at any other time.
- R7: In continuous mode (cfg_cont=1), the cycle after the done of the last slot shows eos=1, soc=1 and slot_idx=0, and the run repeats.
- R8: A stop request while busy, whether before or together with a done, lets the current conversion finish. The cycle after that done shows busy=0 and soc=0. A stop request while idle has no effect on a later run.
- R9: The configuration is sampled only on an accepted start. Changes to the cfg inputs while busy do not alter the running sequence.
- R10: A start request while busy is ignored, so the slot order continues unchanged. A done while idle is ignored, so busy, soc and eos stay 0.
- R11: chan shows the table entry of slot_idx. A write (tbl_we=1) stores tbl_data into entry tbl_addr at the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_req | input | 1 | Start a sequence (used when idle) |
| stop_req | input | 1 | Stop after the conversion in progress |
| done_in | input | 1 | Conversion-done pulse from converter timing |
| cfg_cont | input | 1 | 1 = continuous, 0 = single sequence |
| cfg_seq_on | input | 1 | 1 = sequence mode, 0 = slot 0 only |
| cfg_len | input | SLOT_W | Last slot index of the sequence |
| tbl_we | input | 1 | Channel table write enable |
| tbl_addr | input | SLOT_W | Channel table write slot |
| tbl_data | input | CH_W | Channel number to store |
| slot_idx | output | SLOT_W | Active slot |
| soc | output | 1 | Start-conversion pulse for the active slot |
| eos | output | 1 | End-of-sequence pulse |
| busy | output | 1 | Sequence running |
| chan | output | CH_W | Channel number mapped to the active slot |

## Verification
The bench uses the default parameters: SLOT_W=4, giving sixteen slots, and CH_W=5. These values put both length extremes within a short run: a one-slot sequence and the full wrap from slot 15 back to 0. They also let the channel table be filled with values that differ from the identity reset pattern. Random runs vary the done latency from zero to three idle cycles. That exposes a stop arriving in the same cycle as a done, a stop arriving earlier, and stray starts or configuration edits in the middle of a run.

// File: rtl/conv_seq_pkg.sv
package conv_seq_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } seq_state_t;

  // index of the final slot: sequence mode off collapses the run to slot 0
  function automatic logic [31:0] eff_last(input logic seq_on, input logic [31:0] len);
    return seq_on ? len : 32'd0;
  endfunction

  // slot that follows cur in a run ending at last
  function automatic logic [31:0] next_index(input logic [31:0] cur, input logic [31:0] last);
    return (cur == last) ? 32'd0 : cur + 32'd1;
  endfunction

endpackage

// File: rtl/cfg_capture.sv
module cfg_capture
  import conv_seq_pkg::*;
#(
  parameter int unsigned SLOT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic              cont_in,
  input  logic              seq_on_in,
  input  logic [SLOT_W-1:0] len_in,
  output logic              cont_q,
  output logic [SLOT_W-1:0] last_q
);

  logic              seq_on_r;
  logic [SLOT_W-1:0] len_r;

  // reset leaves sequence mode enabled with a one-slot single run
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cont_q   <= 1'b0;
      seq_on_r <= 1'b1;
      len_r    <= '0;
    end else if (capture) begin
      cont_q   <= cont_in;
      seq_on_r <= seq_on_in;
      len_r    <= len_in;
    end
  end

  assign last_q = SLOT_W'(eff_last(seq_on_r, 32'(len_r)));

endmodule

// File: rtl/slot_counter.sv
module slot_counter
  import conv_seq_pkg::*;
#(
  parameter int unsigned SLOT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              advance,
  input  logic [SLOT_W-1:0] last,
  output logic [SLOT_W-1:0] idx,
  output logic              at_last
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       idx <= '0;
    else if (clear)   idx <= '0;
    else if (advance) idx <= SLOT_W'(next_index(32'(idx), 32'(last)));
  end

  assign at_last = (idx == last);

  // R3
  idx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idx <= last);

endmodule

// File: rtl/seq_fsm.sv
module seq_fsm
  import conv_seq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_req,
  input  logic stop_req,
  input  logic done_in,
  input  logic at_last,
  input  logic cont,
  output logic capture,
  output logic clear,
  output logic advance,
  output logic busy,
  output logic soc,
  output logic eos
);

  seq_state_t state;
  logic       stop_pend;
  logic       soc_q, eos_q;

  // named internal events
  logic start_ok, done_ok, stop_seen, seq_end, halt, step;

  assign start_ok  = (state == ST_IDLE) && start_req;
  assign done_ok   = (state == ST_RUN) && done_in;
  assign stop_seen = stop_pend || stop_req;
  assign seq_end   = done_ok && at_last;
  assign halt      = done_ok && (stop_seen || (at_last && !cont));
  assign step      = done_ok && !halt;

  assign capture = start_ok;
  assign clear   = start_ok || halt;
  assign advance = step;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      stop_pend <= 1'b0;
      soc_q     <= 1'b0;
      eos_q     <= 1'b0;
    end else begin
      if (start_ok)  state <= ST_RUN;
      else if (halt) state <= ST_IDLE;
      stop_pend <= (state == ST_RUN) && !halt && stop_seen;
      soc_q     <= start_ok || step;
      eos_q     <= seq_end;
    end
  end

  assign busy = (state == ST_RUN);
  assign soc  = soc_q;
  assign eos  = eos_q;

  // R2
  soc_in_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soc |-> busy);

  // R6
  eos_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eos |-> $past(done_in));

  // R5
  single_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && done_in && at_last && !cont) |=> (!busy && !soc));

  // R8
  stop_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && done_in && (stop_req || stop_pend)) |=> (!busy && !soc));

  // R10
  idle_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start_req) |=> (!busy && !soc && !eos));

endmodule

// File: rtl/slot_chan_table.sv
module slot_chan_table #(
  parameter int unsigned SLOT_W = 4,
  parameter int unsigned CH_W   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [SLOT_W-1:0] waddr,
  input  logic [CH_W-1:0]   wdata,
  input  logic [SLOT_W-1:0] raddr,
  output logic [CH_W-1:0]   rdata
);

  localparam int unsigned NSLOT = 1 << SLOT_W;

  logic [CH_W-1:0] entry [NSLOT];

  // reset maps slot i onto channel i
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NSLOT; i++) entry[i] <= CH_W'(i);
    end else if (we) begin
      entry[waddr] <= wdata;
    end
  end

  assign rdata = entry[raddr];

  // R11
  write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && raddr == waddr) |=> (rdata == $past(wdata) || $past(raddr) != raddr));

endmodule

// File: rtl/conv_sequencer.sv
module conv_sequencer #(
  parameter int unsigned SLOT_W = 4,
  parameter int unsigned CH_W   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_req,
  input  logic              stop_req,
  input  logic              done_in,
  input  logic              cfg_cont,
  input  logic              cfg_seq_on,
  input  logic [SLOT_W-1:0] cfg_len,
  input  logic              tbl_we,
  input  logic [SLOT_W-1:0] tbl_addr,
  input  logic [CH_W-1:0]   tbl_data,
  output logic [SLOT_W-1:0] slot_idx,
  output logic              soc,
  output logic              eos,
  output logic              busy,
  output logic [CH_W-1:0]   chan
);

  logic              cont_q;
  logic [SLOT_W-1:0] last_q;
  logic              capture, clear, advance, at_last;

  cfg_capture #(.SLOT_W(SLOT_W)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .capture   (capture),
    .cont_in   (cfg_cont),
    .seq_on_in (cfg_seq_on),
    .len_in    (cfg_len),
    .cont_q    (cont_q),
    .last_q    (last_q)
  );

  slot_counter #(.SLOT_W(SLOT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (clear),
    .advance (advance),
    .last    (last_q),
    .idx     (slot_idx),
    .at_last (at_last)
  );

  seq_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_req (start_req),
    .stop_req  (stop_req),
    .done_in   (done_in),
    .at_last   (at_last),
    .cont      (cont_q),
    .capture   (capture),
    .clear     (clear),
    .advance   (advance),
    .busy      (busy),
    .soc       (soc),
    .eos       (eos)
  );

  slot_chan_table #(.SLOT_W(SLOT_W), .CH_W(CH_W)) u_tbl (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (tbl_we),
    .waddr (tbl_addr),
    .wdata (tbl_data),
    .raddr (slot_idx),
    .rdata (chan)
  );

  // R10
  busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start_req && !done_in) |=> ($stable(slot_idx) && !soc));

  // R9
  cfg_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !capture) |=> $stable(last_q));

endmodule

// File: tb/conv_sequencer_bench.sv
module conv_sequencer_bench;
  localparam int CLK_NS = 10;
  localparam int SLOT_W = 4;
  localparam int CH_W   = 5;
  localparam int NSLOT  = 1 << SLOT_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_req = 0, stop_req = 0, done_in = 0;
  logic cfg_cont = 0, cfg_seq_on = 1;
  logic [SLOT_W-1:0] cfg_len = '0;
  logic tbl_we = 0;
  logic [SLOT_W-1:0] tbl_addr = '0;
  logic [CH_W-1:0] tbl_data = '0;
  logic [SLOT_W-1:0] slot_idx;
  logic soc, eos, busy;
  logic [CH_W-1:0] chan;

  int total = 0;
  int bad = 0;
  logic [CH_W-1:0] model_tbl [NSLOT];

  always #(CLK_NS/2) clk = ~clk;

  conv_sequencer #(.SLOT_W(SLOT_W), .CH_W(CH_W)) u_conv_sequencer (
    .clk(clk), .rst_n(rst_n), .start_req(start_req), .stop_req(stop_req),
    .done_in(done_in), .cfg_cont(cfg_cont), .cfg_seq_on(cfg_seq_on),
    .cfg_len(cfg_len), .tbl_we(tbl_we), .tbl_addr(tbl_addr),
    .tbl_data(tbl_data), .slot_idx(slot_idx), .soc(soc), .eos(eos),
    .busy(busy), .chan(chan)
  );

  function automatic int last_of(input bit seq_on, input int len);
    if (!seq_on) return 0;
    return len;
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  task automatic write_tbl(input int addr, input int data);
    tbl_we = 1; tbl_addr = SLOT_W'(addr); tbl_data = CH_W'(data);
    @(negedge clk);
    tbl_we = 0;
    model_tbl[addr] = CH_W'(data);
  endtask

  // starts at a negedge with the block idle; ends at a negedge with it idle
  task automatic run_seq(input bit cont, input bit seq_on, input int len,
                         input int stop_after, input bit scramble, input bit poke);
    int last = last_of(seq_on, len);
    int exp = 0;
    int conv = 0;
    bit finished = 0;
    cfg_cont = cont; cfg_seq_on = seq_on; cfg_len = SLOT_W'(len);
    start_req = 1;
    @(negedge clk);
    start_req = 0;
    if (scramble) begin
      cfg_cont = ~cont; cfg_seq_on = ~seq_on; cfg_len = SLOT_W'($urandom);
    end
    while (!finished && conv < 300) begin
      int d = $urandom_range(0, 3);
      check(conv == 0 ? "R2" : "R3", "soc", soc, 1);
      check("R3", "slot_idx", slot_idx, exp);
      check("R3", "busy", busy, 1);
      check("R11", "chan", chan, model_tbl[exp]);
      conv++;
      for (int i = 0; i < d; i++) begin
        if (poke && i == 0) start_req = 1;
        if (stop_after == conv && i == 0) stop_req = 1;
        @(negedge clk);
        start_req = 0; stop_req = 0;
        check("R10", "soc mid", soc, 0);
        check("R9", "slot mid", slot_idx, exp);
        check("R6", "eos mid", eos, 0);
      end
      if (stop_after == conv && d == 0) stop_req = 1;
      done_in = 1;
      @(negedge clk);
      done_in = 0; stop_req = 0;
      check("R6", "eos", eos, (exp == last) ? 1 : 0);
      if ((stop_after != 0 && conv >= stop_after) || (exp == last && !cont)) begin
        string r = (stop_after != 0 && conv >= stop_after) ? "R8" : "R5";
        check(r, "busy end", busy, 0);
        check(r, "soc end", soc, 0);
        check("R5", "idle slot", slot_idx, 0);
        finished = 1;
      end else begin
        exp = (exp == last) ? 0 : exp + 1;
        if (exp == 0) check("R7", "wrap slot", slot_idx, 0);
      end
    end
    @(negedge clk);
    check("R5", "soc after end", soc, 0);
    cfg_cont = 0; cfg_seq_on = 1; cfg_len = '0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    summary();
  end

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < NSLOT; i++) model_tbl[i] = CH_W'(i);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1", "busy", busy, 0);
    check("R1", "soc", soc, 0);
    check("R1", "eos", eos, 0);
    check("R1", "slot_idx", slot_idx, 0);
    check("R1", "chan", chan, 0);

    // R1 identity table, R3 full length, R5 single halt
    run_seq(0, 1, 15, 0, 0, 0);
    // R4 sequence mode off ignores length
    run_seq(0, 0, 9, 0, 0, 0);
    run_seq(0, 1, 0, 0, 0, 0);
    // R7 continuous wrap, R8 stop
    run_seq(1, 1, 2, 7, 0, 0);
    run_seq(1, 0, 5, 3, 0, 0);
    // R8 stop in single mode mid run
    run_seq(0, 1, 5, 2, 0, 0);
    // R9 config edits and R10 stray starts while busy
    run_seq(0, 1, 4, 0, 1, 1);
    run_seq(1, 1, 15, 20, 1, 1);

    // R10 done while idle
    done_in = 1;
    @(negedge clk);
    done_in = 0;
    check("R10", "idle busy", busy, 0);
    check("R10", "idle soc", soc, 0);
    check("R10", "idle eos", eos, 0);
    // R8 stop while idle has no lasting effect
    stop_req = 1;
    @(negedge clk);
    stop_req = 0;
    run_seq(0, 1, 3, 0, 0, 0);

    // R11 table writes
    write_tbl(0, 21);
    check("R11", "chan slot0", chan, 21);
    for (int i = 1; i < NSLOT; i++) write_tbl(i, $urandom_range(0, (1 << CH_W) - 1));
    run_seq(0, 1, 15, 0, 0, 0);

    for (int k = 0; k < 40; k++) begin
      bit c = 1'($urandom);
      bit s = 1'($urandom_range(0, 3) != 0);
      int l = $urandom_range(0, NSLOT - 1);
      int st = c ? $urandom_range(1, 40) : (($urandom_range(0, 3) == 0) ? $urandom_range(1, 8) : 0);
      run_seq(c, s, l, st, 1'($urandom), 1'($urandom));
    end
    summary();
  end
endmodule